// File: doc/BRIEF.md
# Branch-Resolving Program Counter Unit

This block holds the program counter of a small 16-bit processor and works out its next value on every clock. The instruction decoder supplies three control signals: a branch-request flag, a 3-bit branch kind and a 2-bit target selector. The datapath supplies the instruction register, one register-file operand and four condition flags. When a request is present and the chosen condition holds, the counter loads a target address. Otherwise it steps forward by one.

A target can be the current PC, the PC plus a signed byte offset taken from the instruction, the register operand, or an absolute address formed inside the current 4K page. Selecting the current PC with an unconditional request is how a halt is made: the processor spins on that instruction. The next-PC value is also brought out as a combinational port, so the fetch stage can use it in the same cycle.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0x0000. The reset acts asynchronously, without waiting for a clock edge.
- R2: When `br_req` is 0, `pc_next` is `pc`+1 modulo 2^16, so 0xFFFF wraps to 0x0000. This holds whatever the other control inputs are.
- R3: Branch kind 3'd0 (always) is taken on every request.
- R4: Branch kind 3'd1 (less than) is taken exactly when N xor V is 1. The flags are laid out as `flags[3]`=N, `flags[2]`=Z, `flags[1]`=C, `flags[0]`=V.
- R5: Branch kind 3'd2 (not equal) is taken exactly when Z is 0.
- R6: The remaining kinds test these conditions: 3'd3 equal (Z=1), 3'd4 greater or equal (N xor V = 0), 3'd5 carry set (C=1), 3'd6 carry clear (C=0), 3'd7 negative (N=1).
- R7: A request whose condition is false gives `pc_next` = `pc`+1.
- R8: Target select 2'd0 gives the current PC. An always-taken request with this select holds `pc` unchanged (halt).
- R9: Target select 2'd1 gives `pc` plus `ir[7:0]` sign-extended to 16 bits, modulo 2^16.
- R10: Target select 2'd2 gives `reg_a`.
- R11: Target select 2'd3 gives `{pc[15:12], ir[11:0]}`.
- R12: `pc` loads `pc_next` on each rising clock edge once reset has been released. After `rst_n` rises, `pc` stays 0x0000 through the first two rising edges and first moves on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ir | input | 16 | Instruction register |
| reg_a | input | 16 | Register-file operand used as a branch target |
| flags | input | 4 | Condition flags {N, Z, C, V} |
| br_req | input | 1 | Branch request from the decoder |
| br_kind | input | 3 | Branch condition kind |
| tgt_sel | input | 2 | Target address selector |
| pc | output | 16 | Current program counter |
| pc_next | output | 16 | Combinational next program counter |

## Verification
Every condition kind is driven with its flags both true and false. A decoder that swaps two kinds, or tests Z where it should test N xor V, then takes or skips the wrong branch and PC+1 shows up where a target was expected. Relative targets are tried with the largest positive and negative offsets and with wrap across 0xFFFF. A design that zero-extends the offset or drops the carry jumps forward instead of backward. Halt is repeated so that a self-target built from PC+1 would drift. The reset release is checked edge by edge, and a mid-run reset is checked to see that it clears the PC without a clock.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;

  typedef enum logic [2:0] {
    BK_ALWAYS = 3'd0,
    BK_LT     = 3'd1,
    BK_NE     = 3'd2,
    BK_EQ     = 3'd3,
    BK_GE     = 3'd4,
    BK_CS     = 3'd5,
    BK_CC     = 3'd6,
    BK_MI     = 3'd7
  } br_kind_e;

  typedef enum logic [1:0] {
    TS_SELF = 2'd0,
    TS_REL  = 2'd1,
    TS_REG  = 2'd2,
    TS_ABS  = 2'd3
  } tgt_sel_e;

  localparam int FLAG_W = 4;
  localparam int FL_N   = 3;
  localparam int FL_Z   = 2;
  localparam int FL_C   = 1;
  localparam int FL_V   = 0;

endpackage

// File: rtl/pc_unit_rst_sync.sv
module pc_unit_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb shift_d = 1'b1;
    end else begin : g_many
      always_comb shift_d = {shift_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign run = shift_q[STAGES-1];

endmodule

// File: rtl/pc_unit_cond.sv
module pc_unit_cond
  import pc_unit_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [2:0]        br_kind,
  output logic              cond_ok
);

  logic f_n, f_z, f_c, f_v, lt;

  assign f_n = flags[FL_N];
  assign f_z = flags[FL_Z];
  assign f_c = flags[FL_C];
  assign f_v = flags[FL_V];
  assign lt  = f_n ^ f_v;

  always_comb begin
    unique case (br_kind_e'(br_kind))
      BK_ALWAYS: cond_ok = 1'b1;
      BK_LT:     cond_ok = lt;
      BK_NE:     cond_ok = ~f_z;
      BK_EQ:     cond_ok = f_z;
      BK_GE:     cond_ok = ~lt;
      BK_CS:     cond_ok = f_c;
      BK_CC:     cond_ok = ~f_c;
      BK_MI:     cond_ok = f_n;
      default:   cond_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/pc_unit_target.sv
module pc_unit_target
  import pc_unit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IR_W   = 16,
  parameter int OFF_W  = 8,
  parameter int ABS_W  = 12
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [IR_W-1:0]   ir,
  input  logic [ADDR_W-1:0] reg_a,
  input  logic [1:0]        tgt_sel,
  output logic [ADDR_W-1:0] target
);

  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_sx;
  logic [ADDR_W-1:0] rel_tgt;
  logic [ADDR_W-1:0] abs_tgt;

  assign off_sx  = {{EXT_W{ir[OFF_W-1]}}, ir[OFF_W-1:0]};
  assign rel_tgt = pc + off_sx;

  // keep the page bits of the PC above the absolute field, when there are any
  generate
    if (ABS_W < ADDR_W) begin : g_paged
      assign abs_tgt = {pc[ADDR_W-1:ABS_W], ir[ABS_W-1:0]};
    end else begin : g_flat
      assign abs_tgt = ir[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (tgt_sel_e'(tgt_sel))
      TS_SELF: target = pc;
      TS_REL:  target = rel_tgt;
      TS_REG:  target = reg_a;
      TS_ABS:  target = abs_tgt;
      default: target = pc;
    endcase
  end

endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_unit_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int IR_W        = 16,
  parameter int OFF_W       = 8,
  parameter int ABS_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir,
  input  logic [ADDR_W-1:0] reg_a,
  input  logic [3:0]        flags,
  input  logic              br_req,
  input  logic [2:0]        br_kind,
  input  logic [1:0]        tgt_sel,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] pc_next
);

  logic              run;
  logic              cond_ok;
  logic              taken;
  logic              pc_en;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;

  pc_unit_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  pc_unit_cond u_cond (
    .flags   (flags),
    .br_kind (br_kind),
    .cond_ok (cond_ok)
  );

  pc_unit_target #(
    .ADDR_W (ADDR_W),
    .IR_W   (IR_W),
    .OFF_W  (OFF_W),
    .ABS_W  (ABS_W)
  ) u_tgt (
    .pc      (pc_q),
    .ir      (ir),
    .reg_a   (reg_a),
    .tgt_sel (tgt_sel),
    .target  (target)
  );

  // next-state
  always_comb begin
    taken = br_req & cond_ok;
    pc_d  = taken ? target : pc_q + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  assign pc_en = run;

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (!run) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign pc      = pc_q;
  assign pc_next = pc_d;

endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              br_req,
  input logic [2:0]        br_kind,
  input logic [1:0]        tgt_sel,
  input logic [3:0]        flags,
  input logic [ADDR_W-1:0] reg_a,
  input logic [ADDR_W-1:0] pc
);

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |=> pc == '0);

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !br_req) |=> pc == $past(pc) + 1'b1);

  // R8
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && br_req && br_kind == 3'd0 && tgt_sel == 2'd0) |=> $stable(pc));

  // R10
  reg_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && br_req && br_kind == 3'd0 && tgt_sel == 2'd2) |=> pc == $past(reg_a));

  // R5 R7
  ne_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && br_req && br_kind == 3'd2 && flags[2]) |=> pc == $past(pc) + 1'b1);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc == '0);

endmodule

bind pc_unit pc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .br_req  (br_req),
  .br_kind (br_kind),
  .tgt_sel (tgt_sel),
  .flags   (flags),
  .reg_a   (reg_a),
  .pc      (pc)
);

// File: tb/pc_unit_tb.sv
`timescale 1ns/1ps
module pc_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] ir;
  logic [15:0] reg_a;
  logic [3:0]  flags;
  logic        br_req;
  logic [2:0]  br_kind;
  logic [1:0]  tgt_sel;
  logic [15:0] pc;
  logic [15:0] pc_next;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ir(ir), .reg_a(reg_a), .flags(flags),
    .br_req(br_req), .br_kind(br_kind), .tgt_sel(tgt_sel),
    .pc(pc), .pc_next(pc_next)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit ref_cond(input logic [2:0] k, input logic [3:0] f);
    bit n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (k)
      3'd0: return 1'b1;
      3'd1: return n ^ v;
      3'd2: return !z;
      3'd3: return z;
      3'd4: return !(n ^ v);
      3'd5: return c;
      3'd6: return !c;
      default: return n;
    endcase
  endfunction

  function automatic logic [15:0] ref_next(input logic [15:0] p, input logic [15:0] i,
      input logic [15:0] ra, input logic [3:0] f, input logic rq,
      input logic [2:0] k, input logic [1:0] s);
    logic [15:0] t;
    case (s)
      2'd0: t = p;
      2'd1: t = p + {{8{i[7]}}, i[7:0]};
      2'd2: t = ra;
      default: t = {p[15:12], i[11:0]};
    endcase
    if (rq && ref_cond(k, f)) return t;
    return p + 16'd1;
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rq, input logic [2:0] k, input logic [1:0] s,
      input logic [3:0] f, input logic [15:0] i, input logic [15:0] ra, input string tag);
    logic [15:0] e;
    @(negedge clk);
    br_req = rq; br_kind = k; tgt_sel = s; flags = f; ir = i; reg_a = ra;
    #1;
    e = ref_next(pc, i, ra, f, rq, k, s);
    check(pc_next, e, tag);
    @(posedge clk);
    #1;
    check(pc, e, tag);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1; check(pc, 16'h0000, "R12 first edge");
    @(posedge clk); #1; check(pc, 16'h0000, "R12 second edge");
    @(posedge clk); #1; check(pc, 16'h0001, "R12 third edge");
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; br_req = 1'b0; br_kind = '0; tgt_sel = '0;
    flags = '0; ir = '0; reg_a = '0;
    repeat (3) @(posedge clk);
    #1;
    check(pc, 16'h0000, "R1 reset");
    br_req = 1'b1; reg_a = 16'h1234; tgt_sel = 2'd2; #1;
    check(pc, 16'h0000, "R1 reset ignores request");
    br_req = 1'b0;
    release_reset();

    // R2 plain step and wrap
    step(1'b0, 3'd0, 2'd2, 4'hF, 16'hFFFF, 16'h5555, "R2 no request");
    step(1'b1, 3'd0, 2'd2, 4'h0, 16'h0000, 16'hFFFF, "R10 load FFFF");
    step(1'b0, 3'd0, 2'd0, 4'h0, 16'h0000, 16'h0000, "R2 wrap");
    // R3 / R8 halt loop
    step(1'b1, 3'd0, 2'd2, 4'h0, 16'h0000, 16'h4000, "R10 load 4000");
    step(1'b1, 3'd0, 2'd0, 4'h0, 16'h0000, 16'h0000, "R8 halt");
    step(1'b1, 3'd0, 2'd0, 4'h0, 16'h0000, 16'h0000, "R8 halt again");
    // R4 less than
    step(1'b1, 3'd1, 2'd1, 4'b1000, 16'h0010, 16'h0, "R4 N^V true");
    step(1'b1, 3'd1, 2'd1, 4'b1001, 16'h0010, 16'h0, "R4 R7 N^V false");
    step(1'b1, 3'd1, 2'd1, 4'b0001, 16'h00F0, 16'h0, "R4 V only");
    // R5 not equal
    step(1'b1, 3'd2, 2'd1, 4'b0000, 16'h0020, 16'h0, "R5 Z clear");
    step(1'b1, 3'd2, 2'd1, 4'b0100, 16'h0020, 16'h0, "R5 R7 Z set");
    // R6 other kinds, true then false
    step(1'b1, 3'd3, 2'd3, 4'b0100, 16'h0ABC, 16'h0, "R6 R11 EQ true");
    step(1'b1, 3'd3, 2'd3, 4'b0000, 16'h0123, 16'h0, "R6 EQ false");
    step(1'b1, 3'd4, 2'd3, 4'b1001, 16'h0777, 16'h0, "R6 GE true");
    step(1'b1, 3'd4, 2'd3, 4'b1000, 16'h0111, 16'h0, "R6 GE false");
    step(1'b1, 3'd5, 2'd2, 4'b0010, 16'h0, 16'h8000, "R6 CS true");
    step(1'b1, 3'd5, 2'd2, 4'b1101, 16'h0, 16'h9000, "R6 CS false");
    step(1'b1, 3'd6, 2'd2, 4'b0000, 16'h0, 16'h2222, "R6 CC true");
    step(1'b1, 3'd6, 2'd2, 4'b0010, 16'h0, 16'h3333, "R6 CC false");
    step(1'b1, 3'd7, 2'd2, 4'b1000, 16'h0, 16'hFFF0, "R6 MI true");
    step(1'b1, 3'd7, 2'd2, 4'b0111, 16'h0, 16'h1111, "R6 MI false");
    // R9 relative extremes and wrap
    step(1'b1, 3'd0, 2'd1, 4'h0, 16'hFF7F, 16'h0, "R9 +127");
    step(1'b1, 3'd0, 2'd1, 4'h0, 16'h0080, 16'h0, "R9 -128");
    step(1'b1, 3'd0, 2'd2, 4'h0, 16'h0, 16'h0005, "R10 load 0005");
    step(1'b1, 3'd0, 2'd1, 4'h0, 16'h00F0, 16'h0, "R9 wrap below 0");
    // R11 keeps page bits
    step(1'b1, 3'd0, 2'd2, 4'h0, 16'h0, 16'hA123, "R10 load A123");
    step(1'b1, 3'd0, 2'd3, 4'h0, 16'hF456, 16'h0, "R11 page");

    // random mix
    for (int n = 0; n < 400; n++) begin
      step(1'($urandom), 3'($urandom), 2'($urandom), 4'($urandom),
           16'($urandom), 16'($urandom), "R3 random mix");
    end

    // R1 asynchronous reset mid-run
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check(pc, 16'h0000, "R1 async clear");
    @(posedge clk); #1;
    check(pc, 16'h0000, "R1 held");
    release_reset();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule